// File: doc/BRIEF.md
# Pixel Sample Depth Converter with Noise Dithering

This block sits on a streaming video path and rewrites every colour sample of every pixel from one bit depth to another. A stream beat holds several pixels side by side, each made of several colour planes; every sample in the beat is converted on its own and the whole beat is issued one register stage later, with its end-of-line and start-of-frame markers kept aligned with the data.

When the output is narrower than the input, the low bits are dropped. Before they are dropped, a small amount of pseudo-random noise can be mixed into the sample to break up banding. The noise is drawn from a single 33-bit shift-register generator that steps once for each beat the block takes in. The noise width is set per colour channel, and the noise can be added, subtracted, or added or subtracted per sample according to one generator bit. When the output is wider, the sample is shifted up and the freed low bits are filled with copies of its top bits. An optional register slice can be placed on the input ready path to break a long timing path.

Top module: `bpa_depth_adapter`

## Requirements
- R1: With dithering turned off, or with a channel noise count of 0, a narrowing conversion outputs the input sample shifted right by IN_W-OUT_W.
- R2: A widening conversion outputs {sample, top (OUT_W-IN_W) bits of sample} and applies no noise.
- R3: The noise generator state after reset is {SEED, 3'b111}. On each accepted input beat it becomes {state[31:0], state[32] ^ state[19]}, and it holds in every other cycle.
- R4: For sample index k, noise bit j is state[(7k+j) mod 33]. Only the low N bits are kept, where N is the channel count clamped to IN_W-OUT_W. The count for channel c sits in NOISE_BITS[4c+3:4c]. Channel 0 is blue/Cb, channel 1 is green/Y, channel 2 is red/Cr and channel 3 is alpha.
- R5: Additive mode adds the noise to the input sample and saturates at the all-ones input code before the low bits are dropped.
- R6: Subtractive mode subtracts the noise from the input sample and clamps at zero before the low bits are dropped.
- R7: Combined mode subtracts when state[(7k+8) mod 33] is 1 and adds when it is 0.
- R8: Sample k = pixel*PLANES + plane occupies tdata[k*W +: W] on both sides, where W is that side's sample width.
- R9: Each accepted beat appears on the output exactly once, in order, one cycle after acceptance, with its tlast and tuser.
- R10: While m_tvalid is high and m_tready is low, m_tdata, m_tlast and m_tuser stay unchanged.
- R11: With READY_PIPE=1, s_tready is driven only from a register, so it never changes between clock edges, and no beat is lost or duplicated.
- R12: During and right after reset, m_tvalid is low and s_tready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | PIXELS*PLANES*IN_W | Input samples |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block can take an input beat |
| s_tlast | input | 1 | Input end-of-line marker |
| s_tuser | input | 1 | Input start-of-frame marker |
| m_tdata | output | PIXELS*PLANES*OUT_W | Converted samples |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream can take the output beat |
| m_tlast | output | 1 | Output end-of-line marker |
| m_tuser | output | 1 | Output start-of-frame marker |

## Verification
The delicate case is a downstream stall that lands in the same cycle as an offered input beat. The output must then freeze, the input must not be taken, and the noise generator must not step. If the generator stepped on an offered but refused beat, the noise of every later sample would shift. The bench provokes this case with random m_tready while input beats are offered back to back, and also with idle gaps between beats. It judges the result with a reference generator that steps only on beats it sees accepted, comparing every output beat against a per-instance queue, and by checking that any stalled output stays unchanged until it is taken.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

    typedef enum logic [1:0] {
        DITH_ADD  = 2'd0,
        DITH_SUB  = 2'd1,
        DITH_COMB = 2'd2
    } dith_mode_e;

    localparam int LFSR_W       = 33;
    localparam int NOISE_MAX    = 8;
    localparam int NOISE_STRIDE = 7;

    // Bit of the generator state feeding noise bit j of sample k
    function automatic int tap_index(input int k, input int j);
        return (k * NOISE_STRIDE + j) % LFSR_W;
    endfunction

    function automatic int clamp_bits(input int req, input int lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/bpa_lfsr.sv
module bpa_lfsr
    import bpa_pkg::*;
#(
    parameter logic [29:0] SEED = 30'h15A5C3E1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [LFSR_W-1:0] state_o
);

    localparam logic [LFSR_W-1:0] INIT = {SEED, 3'b111};

    logic [LFSR_W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (advance) begin
            state_d = {state_q[LFSR_W-2:0], state_q[32] ^ state_q[19]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R3
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state_q)); // R3
    AST_LFSR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> state_q != $past(state_q)); // R3

endmodule

// File: rtl/bpa_sample_conv.sv
module bpa_sample_conv
    import bpa_pkg::*;
#(
    parameter int unsigned IN_W      = 10,
    parameter int unsigned OUT_W     = 8,
    parameter bit          DITHER_EN = 1'b1,
    parameter dith_mode_e  MODE      = DITH_ADD,
    parameter int unsigned NB        = 2
) (
    input  logic [IN_W-1:0]      sample_i,
    input  logic [NOISE_MAX-1:0] noise_i,
    input  logic                 sign_i,
    output logic [OUT_W-1:0]     sample_o
);

    generate
        if (IN_W > OUT_W) begin : g_narrow
            localparam int DROP   = IN_W - OUT_W;
            localparam int NB_EFF = DITHER_EN ? clamp_bits(NB, DROP) : 0;
            localparam logic [IN_W:0] MAX_IN = {1'b0, {IN_W{1'b1}}};

            logic [IN_W:0] noise_ext, wide_in, sum_v, val_v;
            logic          do_sub;
            wire           unused_noise = ^noise_i;

            always_comb begin
                noise_ext = '0;
                for (int j = 0; j < NB_EFF; j++) begin
                    noise_ext[j] = noise_i[j];
                end
                wide_in = {1'b0, sample_i};
                do_sub  = (MODE == DITH_SUB) || ((MODE == DITH_COMB) && sign_i);
                sum_v   = wide_in + noise_ext;
                if (sum_v > MAX_IN) begin
                    sum_v = MAX_IN;
                end
                if (do_sub) begin
                    val_v = (wide_in < noise_ext) ? '0 : (wide_in - noise_ext);
                end else begin
                    val_v = sum_v;
                end
            end

            assign sample_o = val_v[IN_W-1:DROP];

            always_comb begin
                if (!$isunknown({sample_i, sample_o, do_sub})) begin
                    if (!do_sub) begin
                        AST_ADD_FLOOR: assert (sample_o >= sample_i[IN_W-1:DROP]); // R5
                    end else begin
                        AST_SUB_CEIL: assert (sample_o <= sample_i[IN_W-1:DROP]); // R6
                    end
                end
            end
        end else if (IN_W < OUT_W) begin : g_widen
            localparam int GROW = OUT_W - IN_W;
            wire unused_noise = ^{noise_i, sign_i};
            assign sample_o = {sample_i, sample_i[IN_W-1 -: GROW]};
        end else begin : g_same
            wire unused_noise = ^{noise_i, sign_i};
            assign sample_o = sample_i;
        end
    endgenerate

endmodule

// File: rtl/bpa_ready_slice.sv
module bpa_ready_slice #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_data,
    output logic         m_valid,
    input  logic         m_ready,
    output logic [W-1:0] m_data
);

    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } slice_t;

    slice_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.full) begin
            if (m_ready) begin
                st_d.full = 1'b0;
            end
        end else if (s_valid && !m_ready) begin
            st_d.full = 1'b1;
            st_d.data = s_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready = !st_q.full;
    assign m_valid = st_q.full || s_valid;
    assign m_data  = st_q.full ? st_q.data : s_data;

    AST_SLICE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full && !m_ready |=> st_q.full && $stable(st_q.data)); // R11
    AST_SLICE_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid && s_ready && !m_ready |=> st_q.full && m_valid); // R11

endmodule

// File: rtl/bpa_depth_adapter.sv
module bpa_depth_adapter
    import bpa_pkg::*;
#(
    parameter int unsigned IN_W        = 10,
    parameter int unsigned OUT_W       = 8,
    parameter int unsigned PLANES      = 3,
    parameter int unsigned PIXELS      = 2,
    parameter bit          DITHER_EN   = 1'b1,
    parameter dith_mode_e  DITHER_MODE = DITH_ADD,
    parameter logic [29:0] SEED        = 30'h15A5C3E1,
    parameter logic [15:0] NOISE_BITS  = 16'h0012,
    parameter bit          READY_PIPE  = 1'b0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PIXELS*PLANES*IN_W-1:0]   s_tdata,
    input  logic                            s_tvalid,
    output logic                            s_tready,
    input  logic                            s_tlast,
    input  logic                            s_tuser,
    output logic [PIXELS*PLANES*OUT_W-1:0]  m_tdata,
    output logic                            m_tvalid,
    input  logic                            m_tready,
    output logic                            m_tlast,
    output logic                            m_tuser
);

    localparam int SAMPLES = PIXELS * PLANES;
    localparam int IN_BUS  = SAMPLES * IN_W;
    localparam int OUT_BUS = SAMPLES * OUT_W;
    localparam int SLICE_W = IN_BUS + 2;

    typedef struct packed {
        logic               vld;
        logic               last;
        logic               user;
        logic [OUT_BUS-1:0] data;
    } out_t;

    logic               core_valid, core_ready, core_last, core_user, accept;
    logic [IN_BUS-1:0]  core_data;
    logic [OUT_BUS-1:0] conv_data;
    logic [LFSR_W-1:0]  lfsr_state;
    wire                unused_state = ^lfsr_state;

    out_t out_d, out_q;

    generate
        if (READY_PIPE) begin : g_slice
            bpa_ready_slice #(.W(SLICE_W)) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .s_valid (s_tvalid),
                .s_ready (s_tready),
                .s_data  ({s_tlast, s_tuser, s_tdata}),
                .m_valid (core_valid),
                .m_ready (core_ready),
                .m_data  ({core_last, core_user, core_data})
            );
        end else begin : g_direct
            assign core_valid = s_tvalid;
            assign s_tready   = core_ready;
            assign core_data  = s_tdata;
            assign core_last  = s_tlast;
            assign core_user  = s_tuser;
        end
    endgenerate

    assign core_ready = !out_q.vld || m_tready;
    assign accept     = core_valid && core_ready;

    bpa_lfsr #(.SEED(SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept),
        .state_o (lfsr_state)
    );

    generate
        for (genvar k = 0; k < SAMPLES; k++) begin : g_lane
            localparam int CH  = k % PLANES;
            localparam int NBC = int'(NOISE_BITS[4*CH +: 4]);

            logic [NOISE_MAX-1:0] noise_k;
            logic                 sign_k;

            always_comb begin
                for (int j = 0; j < NOISE_MAX; j++) begin
                    noise_k[j] = lfsr_state[tap_index(k, j)];
                end
                sign_k = lfsr_state[tap_index(k, NOISE_MAX)];
            end

            bpa_sample_conv #(
                .IN_W      (IN_W),
                .OUT_W     (OUT_W),
                .DITHER_EN (DITHER_EN),
                .MODE      (DITHER_MODE),
                .NB        (NBC)
            ) u_conv (
                .sample_i (core_data[k*IN_W +: IN_W]),
                .noise_i  (noise_k),
                .sign_i   (sign_k),
                .sample_o (conv_data[k*OUT_W +: OUT_W])
            );
        end
    endgenerate

    always_comb begin
        out_d = out_q;
        if (core_ready) begin
            out_d.vld = core_valid;
            if (core_valid) begin
                out_d.data = conv_data;
                out_d.last = core_last;
                out_d.user = core_user;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign m_tvalid = out_q.vld;
    assign m_tdata  = out_q.data;
    assign m_tlast  = out_q.last;
    assign m_tuser  = out_q.user;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)
                                  && $stable(m_tlast) && $stable(m_tuser)); // R10
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> m_tvalid); // R9
    AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        !core_valid && m_tready |=> !m_tvalid); // R9

endmodule

// File: tb/bpa_depth_adapter_bench.sv
`timescale 1ns/1ps
module bpa_depth_adapter_bench;
    import bpa_pkg::*;

    localparam int NI = 5;
    localparam int NS = 6;
    localparam logic [29:0] SEED = 30'h15A5C3E1;
    localparam int OUTW [NI] = '{8, 8, 8, 8, 12};
    localparam int MODE [NI] = '{0, 1, 2, 0, 0};
    localparam int EN   [NI] = '{1, 1, 1, 0, 1};
    localparam logic [15:0] NBP [NI] = '{16'h0012, 16'h0232, 16'h0222, 16'h0222, 16'h0222};
    localparam string TAG [NI] = '{"R5", "R6", "R7", "R1", "R2"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [59:0] s_tdata = '0;
    logic s_tlast = 1'b0, s_tuser = 1'b0;
    logic [NI-1:0] s_tvalid = '0;
    logic [NI-1:0] s_tready, m_tvalid, m_tlast, m_tuser;
    logic m_tready = 1'b1;
    logic bp_on = 1'b0;
    logic [47:0] md [4];
    logic [71:0] md4;
    logic [73:0] mout [NI];

    int n_chk = 0, n_fail = 0;
    logic [32:0] mst [NI];
    logic [73:0] expq [NI][$];
    logic [73:0] held [NI];
    logic [NI-1:0] held_v = '0;

    always #4 clk = ~clk;

    bpa_depth_adapter u_bpa_depth_adapter (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid[0]), .s_tready(s_tready[0]),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(md[0]), .m_tvalid(m_tvalid[0]),
        .m_tready(m_tready), .m_tlast(m_tlast[0]), .m_tuser(m_tuser[0]));

    bpa_depth_adapter #(.DITHER_MODE(DITH_SUB), .NOISE_BITS(16'h0232), .READY_PIPE(1'b1)) u_sub (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid[1]), .s_tready(s_tready[1]),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(md[1]), .m_tvalid(m_tvalid[1]),
        .m_tready(m_tready), .m_tlast(m_tlast[1]), .m_tuser(m_tuser[1]));

    bpa_depth_adapter #(.DITHER_MODE(DITH_COMB), .NOISE_BITS(16'h0222)) u_comb (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid[2]), .s_tready(s_tready[2]),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(md[2]), .m_tvalid(m_tvalid[2]),
        .m_tready(m_tready), .m_tlast(m_tlast[2]), .m_tuser(m_tuser[2]));

    bpa_depth_adapter #(.DITHER_EN(1'b0), .NOISE_BITS(16'h0222)) u_plain (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid[3]), .s_tready(s_tready[3]),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(md[3]), .m_tvalid(m_tvalid[3]),
        .m_tready(m_tready), .m_tlast(m_tlast[3]), .m_tuser(m_tuser[3]));

    bpa_depth_adapter #(.OUT_W(12), .NOISE_BITS(16'h0222)) u_wide (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid[4]), .s_tready(s_tready[4]),
        .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(md4), .m_tvalid(m_tvalid[4]),
        .m_tready(m_tready), .m_tlast(m_tlast[4]), .m_tuser(m_tuser[4]));

    always_comb begin
        for (int i = 0; i < 4; i++) mout[i] = {m_tlast[i], m_tuser[i], 24'b0, md[i]};
        mout[4] = {m_tlast[4], m_tuser[4], md4};
    end

    task automatic tally(input bit ok, input string req, input logic [73:0] act, input logic [73:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference for R1 R2 R4 R5 R6 R7 R8: samples placed at k*W per R8
    function automatic logic [71:0] model(input int i, input logic [59:0] din, input logic [32:0] st);
        logic [71:0] r;
        r = '0;
        for (int k = 0; k < NS; k++) begin
            int c, x, y, nb, n, v;
            bit sub;
            c = k % 3;
            x = int'(din[k*10 +: 10]);
            if (OUTW[i] == 12) begin
                y = (x << 2) | (x >> 8);
                r[k*12 +: 12] = 12'(y);
            end else begin
                nb = EN[i] != 0 ? int'(NBP[i][4*c +: 4]) : 0;
                if (nb > 2) nb = 2;
                n = 0;
                for (int j = 0; j < nb; j++) if (st[(7*k + j) % 33]) n += (1 << j);
                sub = (MODE[i] == 1) || (MODE[i] == 2 && st[(7*k + 8) % 33]);
                if (sub) v = (x < n) ? 0 : x - n;
                else     v = (x + n > 1023) ? 1023 : x + n;
                y = v >> 2;
                r[k*8 +: 8] = 8'(y);
            end
        end
        return r;
    endfunction

    // Output monitor: order and content (R9, R3 R4 R8), hold under stall (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NI; i++) begin
                if (held_v[i]) tally(mout[i] == held[i], "R10 hold", mout[i], held[i]);
                held_v[i] = m_tvalid[i] && !m_tready;
                held[i] = mout[i];
                if (m_tvalid[i] && m_tready) begin
                    if (expq[i].size() == 0) begin
                        tally(1'b0, "R9 extra beat", mout[i], '0);
                    end else begin
                        logic [73:0] e;
                        e = expq[i].pop_front();
                        tally(mout[i] == e, {TAG[i], " R3 R4 R8 R9 beat"}, mout[i], e);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        #2 m_tready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end

    // R11: registered ready of the sliced instance is steady across m_tready changes
    always @(posedge clk) begin
        logic a;
        #1 a = s_tready[1];
        #2 if (rst_n && bp_on) tally(s_tready[1] == a, "R11 ready steady", 74'(s_tready[1]), 74'(a));
    end

    task automatic send_beat(input logic [59:0] d, input bit last, input bit user);
        logic [NI-1:0] acc;
        s_tdata = d; s_tlast = last; s_tuser = user;
        s_tvalid = '1;
        while (s_tvalid != '0) begin
            acc = s_tvalid & s_tready;
            for (int i = 0; i < NI; i++) begin
                if (acc[i]) begin
                    expq[i].push_back({last, user, model(i, d, mst[i])});
                    mst[i] = {mst[i][31:0], mst[i][32] ^ mst[i][19]};
                end
            end
            @(posedge clk); @(negedge clk);
            s_tvalid = s_tvalid & ~acc;
        end
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (guard < 300 && (expq[0].size() + expq[1].size() + expq[2].size()
                               + expq[3].size() + expq[4].size()) != 0) begin
            @(negedge clk); guard++;
        end
        for (int i = 0; i < NI; i++)
            tally(expq[i].size() == 0, "R9 all beats delivered", 74'(expq[i].size()), '0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        tally(m_tvalid == '0, "R12 valid in reset", 74'(m_tvalid), '0);
        tally(s_tready == '1, "R12 ready in reset", 74'(s_tready), 74'(5'h1f));
        for (int i = 0; i < NI; i++) mst[i] = {SEED, 3'b111};
        rst_n = 1'b1;
        @(negedge clk);
        tally(m_tvalid == '0, "R12 valid after reset", 74'(m_tvalid), '0);
        tally(s_tready == '1, "R12 ready after reset", 74'(s_tready), 74'(5'h1f));
    endtask

    task automatic t_ramp();
        for (int b = 0; b < 16; b++) begin
            logic [59:0] d;
            for (int k = 0; k < NS; k++) d[k*10 +: 10] = 10'((b * 37 + k * 101) % 1024);
            send_beat(d, (b % 4) == 3, b == 0);
        end
        drain();
    endtask

    // R5 saturation at 1023, R6 clamp at 0, R2 replication of top bits
    task automatic t_extremes();
        logic [59:0] pats [6];
        pats[0] = {6{10'h3FF}};
        pats[1] = '0;
        pats[2] = {6{10'h001}};
        pats[3] = {6{10'h3FE}};
        pats[4] = {3{10'h3FF, 10'h000}};
        pats[5] = {6{10'h003}};
        for (int r = 0; r < 3; r++)
            for (int p = 0; p < 6; p++) send_beat(pats[p], p == 5, p == 0);
        drain();
    endtask

    // R3: idle gaps must not step the generator
    task automatic t_gaps();
        for (int b = 0; b < 10; b++) begin
            logic [59:0] d;
            for (int k = 0; k < NS; k++) d[k*10 +: 10] = 10'($urandom);
            send_beat(d, b[0], 1'b0);
            repeat (b % 4) @(negedge clk);
        end
        drain();
    endtask

    // Stall landing on offered beats: R10 R11 R3 R9
    task automatic t_backpressure();
        bp_on = 1'b1;
        for (int b = 0; b < 60; b++) begin
            logic [59:0] d;
            for (int k = 0; k < NS; k++) d[k*10 +: 10] = 10'($urandom);
            send_beat(d, ($urandom % 2) == 0, ($urandom % 5) == 0);
        end
        bp_on = 1'b0;
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_ramp();
        t_extremes();
        t_gaps();
        t_backpressure();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule